// File: doc/BRIEF.md
# Speculative Load Alias Detection Unit

This block lets a code translator move loads above earlier stores without any hardware memory disambiguation. When a load is hoisted, the translator marks it as a protected load. The unit then records the byte range that load read in one slot of a small region table, and the translator names that slot. When the store that the load passed executes, it is marked as a checked store. The unit compares the store's byte range with the table slots picked by a mask. If any byte is shared, it raises an alias exception so that recovery software can re-run the block in program order.

Plain loads and stores never reach this unit. At each translation boundary, a commit or a rollback pulse empties the whole table. The table, the comparators and the exception register are the entire block. The cache, the translator and the recovery code are outside it.

Top module: `spec_alias_unit`

## Requirements
- R1: After synchronous reset every table slot is invalid and `alias_exc` is 0.
- R2: A checked store raises `alias_exc` for exactly one cycle, on the clock edge that ends the check cycle; it is 0 in the following cycle unless another check hits.
- R3: A store of S bytes at A overlaps a recorded region of L bytes at B when A < B+L and B < A+S, with both sums computed without wraparound. Ranges that only touch end to start do not overlap.
- R4: Only slots whose bit is set in `chk_mask` (bit i selects slot i) and that hold a valid region take part in the comparison.
- R5: When `chk_valid` is 0, no exception is produced, whatever the address, size and mask inputs are.
- R6: A `commit` or a `rollback` pulse invalidates all slots in one cycle, so a check in the next cycle finds no region.
- R7: If a protect request and a commit or rollback occur in the same cycle, the clear wins and the slot stays invalid.
- R8: A protect request writes its address and size into slot `prot_idx` and replaces the old contents. A check in the same cycle sees the table as it was before that write.
- R9: Size codes select 1, 2, 4 or 8 bytes for codes 0, 1, 2 and 3 on both the protect and the check ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_valid | input | 1 | Protected-load record request |
| prot_idx | input | 3 | Table slot to fill |
| prot_addr | input | 32 | Start byte address of the load |
| prot_size | input | 2 | Load size code (bytes = 1 << code) |
| chk_valid | input | 1 | Checked-store request |
| chk_addr | input | 32 | Start byte address of the store |
| chk_size | input | 2 | Store size code (bytes = 1 << code) |
| chk_mask | input | 8 | Slots to compare against |
| commit | input | 1 | Clear the table at the end of a block |
| rollback | input | 1 | Clear the table on recovery |
| alias_exc | output | 1 | Registered alias exception pulse |

## Verification
The properties assume that commit and rollback arrive as pulses and that no access range runs past the top of the address space. The stimulus keeps all addresses in a small window far below the top of the address space. Within that window the ranges collide often, yet no end address wraps around. The comparisons therefore depend on the overlap rule alone. The bench also places clears, same-cycle protect-and-clear, and same-cycle protect-and-check at chosen points, so each ordering rule is exercised on purpose rather than left to chance.

// File: rtl/spec_alias_pkg.sv
package spec_alias_pkg;
    parameter int unsigned ADDR_W  = 32;
    parameter int unsigned NUM_ENT = 8;
    localparam int unsigned IDX_W  = $clog2(NUM_ENT);
    localparam int unsigned EXT_W  = ADDR_W + 1;

    typedef logic [1:0] size_code_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] base;
        size_code_t        sz;
    } region_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        size_code_t        sz;
        logic [NUM_ENT-1:0] mask;
    } store_chk_t;

    function automatic logic [EXT_W-1:0] span_end(logic [ADDR_W-1:0] a, size_code_t c);
        logic [EXT_W-1:0] len;
        len = EXT_W'(1) << c;
        return {1'b0, a} + len;
    endfunction

    function automatic logic ranges_meet(logic [ADDR_W-1:0] a, size_code_t ac,
                                         logic [ADDR_W-1:0] b, size_code_t bc);
        return ({1'b0, a} < span_end(b, bc)) && ({1'b0, b} < span_end(a, ac));
    endfunction
endpackage

// File: rtl/alias_region_table.sv
module alias_region_table
    import spec_alias_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  size_code_t        wr_sz,
    input  logic              flush,
    output region_t           regions [NUM_ENT]
);
    region_t tbl_q [NUM_ENT];

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                tbl_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                tbl_q[g].valid <= 1'b1;
                tbl_q[g].base  <= wr_addr;
                tbl_q[g].sz    <= wr_sz;
            end
        end
        assign regions[g] = tbl_q[g];
    end
endmodule

// File: rtl/alias_overlap_array.sv
module alias_overlap_array
    import spec_alias_pkg::*;
(
    input  region_t            regions [NUM_ENT],
    input  store_chk_t         req,
    output logic [NUM_ENT-1:0] hit_vec
);
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        always_comb begin
            hit_vec[g] = req.valid && req.mask[g] && regions[g].valid &&
                         ranges_meet(req.addr, req.sz, regions[g].base, regions[g].sz);
        end
    end
endmodule

// File: rtl/spec_alias_unit.sv
module spec_alias_unit
    import spec_alias_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               prot_valid,
    input  logic [IDX_W-1:0]   prot_idx,
    input  logic [ADDR_W-1:0]  prot_addr,
    input  logic [1:0]         prot_size,
    input  logic               chk_valid,
    input  logic [ADDR_W-1:0]  chk_addr,
    input  logic [1:0]         chk_size,
    input  logic [NUM_ENT-1:0] chk_mask,
    input  logic               commit,
    input  logic               rollback,
    output logic               alias_exc
);
    region_t            regions [NUM_ENT];
    store_chk_t         req;
    logic [NUM_ENT-1:0] hit_vec;
    logic               exc_q;

    assign req = '{valid: chk_valid, addr: chk_addr, sz: chk_size, mask: chk_mask};

    alias_region_table u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (prot_valid),
        .wr_idx  (prot_idx),
        .wr_addr (prot_addr),
        .wr_sz   (prot_size),
        .flush   (commit | rollback),
        .regions (regions)
    );

    alias_overlap_array u_cmp (
        .regions (regions),
        .req     (req),
        .hit_vec (hit_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) exc_q <= 1'b0;
        else     exc_q <= |hit_vec;
    end

    assign alias_exc = exc_q;
endmodule

// File: rtl/spec_alias_chk.sv
module spec_alias_chk
    import spec_alias_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               prot_valid,
    input logic               chk_valid,
    input logic [NUM_ENT-1:0] chk_mask,
    input logic               commit,
    input logic               rollback,
    input logic               alias_exc
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !alias_exc);
    // R5
    only_checked_store_chk: assert property (@(posedge clk) disable iff (rst)
        alias_exc |-> $past(chk_valid));
    // R4
    empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && chk_mask == '0) |=> !alias_exc);
    // R6
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (commit || rollback) |=> ##1 !alias_exc);
    // R7
    clear_beats_protect_chk: assert property (@(posedge clk) disable iff (rst)
        ((commit || rollback) && prot_valid) |=> ##1 !alias_exc);
endmodule

bind spec_alias_unit spec_alias_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .prot_valid (prot_valid),
    .chk_valid  (chk_valid),
    .chk_mask   (chk_mask),
    .commit     (commit),
    .rollback   (rollback),
    .alias_exc  (alias_exc)
);

// File: tb/spec_alias_unit_tb.sv
module spec_alias_unit_tb_top;
    logic        clk = 0;
    logic        rst;
    logic        prot_valid;
    logic [2:0]  prot_idx;
    logic [31:0] prot_addr;
    logic [1:0]  prot_size;
    logic        chk_valid;
    logic [31:0] chk_addr;
    logic [1:0]  chk_size;
    logic [7:0]  chk_mask;
    logic        commit;
    logic        rollback;
    logic        alias_exc;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    bit      m_valid [8];
    longint  m_base  [8];
    longint  m_len   [8];

    always #5 clk = ~clk;

    spec_alias_unit dut_i (.*);

    function automatic bit meets(longint a, longint al, longint b, longint bl);
        return (a < b + bl) && (b < a + al);
    endfunction

    task automatic idle();
        prot_valid = 0; prot_idx = 0; prot_addr = 0; prot_size = 0;
        chk_valid = 0; chk_addr = 0; chk_size = 0; chk_mask = 0;
        commit = 0; rollback = 0;
    endtask

    task automatic expect_exc(string tag, bit exp);
        checks++;
        if (alias_exc !== exp) begin
            errors++;
            $display("FAIL %s: alias_exc=%b expected=%b at %0t", tag, alias_exc, exp, $time);
        end
    endtask

    // One clock: model predicts from pre-edge state, then is updated, then compared.
    task automatic step(string tag);
        bit exp = 0;
        if (chk_valid)
            for (int i = 0; i < 8; i++)
                if (chk_mask[i] && m_valid[i] &&
                    meets(longint'(chk_addr), longint'(1) << chk_size, m_base[i], m_len[i]))
                    exp = 1;
        @(posedge clk);
        if (commit || rollback) begin
            for (int i = 0; i < 8; i++) m_valid[i] = 0;
        end else if (prot_valid) begin
            m_valid[prot_idx] = 1;
            m_base[prot_idx]  = longint'(prot_addr);
            m_len[prot_idx]   = longint'(1) << prot_size;
        end
        #1;
        expect_exc(tag, exp);
        idle();
    endtask

    task automatic prot(int idx, int addr, int sc);
        prot_valid = 1; prot_idx = 3'(idx); prot_addr = 32'(addr); prot_size = 2'(sc);
    endtask

    task automatic chk(int addr, int sc, int mask);
        chk_valid = 1; chk_addr = 32'(addr); chk_size = 2'(sc); chk_mask = 8'(mask);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        for (int i = 0; i < 8; i++) m_valid[i] = 0;
        rst = 1;
        @(posedge clk); @(posedge clk); #1;
        expect_exc("R1 reset", 0);
        rst = 0;
        // R1: table empty after reset
        chk(32'h100, 3, 8'hFF); step("R1 empty table");
        step("R1 idle");

        // R3 / R9: 4-byte region at 0x100
        prot(0, 32'h100, 2); step("R8 protect");
        chk(32'h103, 0, 8'hFF); step("R3 inside hit");
        step("R2 pulse drops");
        chk(32'h104, 2, 8'hFF); step("R3 adjacent above no hit");
        chk(32'h0FC, 2, 8'hFF); step("R3 adjacent below no hit");
        chk(32'h0FD, 2, 8'hFF); step("R3 partial overlap hit");
        chk(32'h0F8, 3, 8'hFF); step("R9 8-byte store touching no hit");
        chk(32'h0F9, 3, 8'hFF); step("R9 8-byte store hit");
        // R4: mask excludes slot 0
        chk(32'h100, 2, 8'hFE); step("R4 masked slot no hit");
        chk(32'h100, 2, 8'h01); step("R4 selected slot hit");
        chk(32'h300, 2, 8'h02); step("R4 invalid slot no hit");
        // R5: unmarked store
        chk_addr = 32'h100; chk_size = 2; chk_mask = 8'hFF; step("R5 unmarked store");
        // R8: overwrite slot 0
        prot(0, 32'h200, 1); step("R8 overwrite");
        chk(32'h100, 2, 8'hFF); step("R8 old region gone");
        chk(32'h201, 0, 8'hFF); step("R9 2-byte region hit");
        chk(32'h202, 0, 8'hFF); step("R9 2-byte region end");
        // R8: same-cycle protect and check
        prot(3, 32'h400, 0); chk(32'h400, 0, 8'hFF); step("R8 same cycle not seen");
        chk(32'h400, 0, 8'h08); step("R8 seen next cycle");
        // R6: commit then rollback
        commit = 1; step("R6 commit");
        chk(32'h400, 0, 8'hFF); step("R6 after commit no hit");
        prot(5, 32'h500, 3); step("R6 refill");
        rollback = 1; step("R6 rollback");
        chk(32'h507, 0, 8'hFF); step("R6 after rollback no hit");
        // R7
        prot(2, 32'h600, 2); commit = 1; step("R7 clear with protect");
        chk(32'h600, 2, 8'hFF); step("R7 slot stays invalid");

        // Random mix in a small window
        for (int n = 0; n < 400; n++) begin
            int r = $urandom_range(0, 99);
            if (r < 40) prot($urandom_range(0, 7), 32'h1000 + $urandom_range(0, 63), $urandom_range(0, 3));
            if (r >= 30) chk(32'h1000 + $urandom_range(0, 63), $urandom_range(0, 3), $urandom_range(0, 255));
            if (r > 95) commit = 1;
            else if (r > 92) rollback = 1;
            step("R3 random mix");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule